// File: doc/BRIEF.md
# SDRAM Read-Latency and Burst Strobe Generator

This block sits on the controller side of an SDRAM interface. It keeps its own copy of the memory's mode settings: read latency, burst length and whether writes are single-location. From READ and WRITE command strobes it produces cycle-accurate strobes. One marks the cycles in which read data is valid on the bus. One warns a cycle ahead that the memory is about to drive the bus. One requests write data for each beat the memory will accept.

A mode load presents a 12-bit word on `mode_word` with `mode_load` high for one cycle. The block checks the word and either applies it or rejects it and raises `mode_err`. After that, the command scheduler pulses `rd_cmd` or `wr_cmd` in the cycle it issues the command, and the datapath follows `rd_valid`, `rd_turn` and `wr_req`. A "READ at edge n" means `rd_cmd` is sampled high at rising edge n. A strobe "after edge k" is the registered value held in the cycle that follows edge k.

Top module: `sdram_burst_timer`

## Requirements
- R1: After reset, `rd_valid`, `rd_turn`, `wr_req` and `mode_err` are low, and the settings are read latency 2, burst length 1, writes bursting.
- R2: Word bits [6:4] select the read latency: 001 gives 1, 010 gives 2, 011 gives 3. Any other value is rejected: `mode_err` goes high and all previous settings stay in force.
- R3: For a READ at edge n with latency m, `rd_valid` first goes high after edge n+m.
- R4: `rd_turn` is high for exactly one cycle, after edge n+m-1, which is the cycle before the first `rd_valid` cycle.
- R5: `rd_valid` stays high for exactly burst-length consecutive cycles. Word bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives PAGE_LEN when FULL_PAGE_EN is set. Any other value is rejected as in R2.
- R6: A READ while a read burst is pending or running discards it. `rd_valid` is low after the new READ's edge, and the strobes then follow the new READ alone.
- R7: Word bits [8:7] must be 00. Any other value is rejected as in R2.
- R8: With word bit 9 at 0, `wr_req` is high in the cycle `wr_cmd` is high (combinationally) and stays high for burst-length cycles in total.
- R9: With word bit 9 at 1, `wr_req` is high for the WRITE cycle only, while reads keep the programmed burst length.
- R10: A mode load is ignored, and `mode_err` is set, if a read or write burst is pending or running, or if `rd_cmd` or `wr_cmd` is high in the same cycle.
- R11: An accepted mode load clears `mode_err`. Without a load, `mode_err` and the settings hold.
- R12: A WRITE during a write burst restarts the count, so `wr_req` lasts burst-length cycles from the latest WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load `mode_word` this cycle |
| mode_word | input | 12 | Mode word: [2:0] burst, [6:4] latency, [8:7] op mode, [9] single-location writes |
| rd_cmd | input | 1 | READ issued this cycle |
| wr_cmd | input | 1 | WRITE issued this cycle |
| rd_valid | output | 1 | Read data valid on the bus this cycle |
| rd_turn | output | 1 | Memory starts driving the bus; first valid beat is next cycle |
| wr_req | output | 1 | Supply write data this cycle |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The hardest condition to reach from the ports is a mode load that arrives while a read is still counting down its latency or streaming beats. Nothing at the ports shows that this load was refused except `mode_err`. The stimulus therefore issues a READ, presents a conflicting load two cycles later, waits for the bus to fall idle, and then issues another READ whose strobe timing shows that the old latency and burst length were kept. A second case presents a load in the same cycle as a WRITE, and a restarted READ and WRITE are issued mid-burst to show that the pattern follows the later command.

// File: rtl/sdram_bt_pkg.sv
package sdram_bt_pkg;

  // Layout of the 12-bit mode word as the memory decodes it.
  typedef struct packed {
    logic [1:0] spare;
    logic       wr_single;
    logic [1:0] op;
    logic [2:0] lat;
    logic       order;
    logic [2:0] blen;
  } mode_word_t;

  localparam logic [2:0] BL_1    = 3'b000;
  localparam logic [2:0] BL_2    = 3'b001;
  localparam logic [2:0] BL_4    = 3'b010;
  localparam logic [2:0] BL_8    = 3'b011;
  localparam logic [2:0] BL_PAGE = 3'b111;

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_bt_pkg::*;
#(
  parameter int PAGE_LEN     = 256,
  parameter bit FULL_PAGE_EN = 1'b1,
  parameter int RST_LAT      = 2,
  parameter int LW           = $clog2(PAGE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [11:0]   word,
  input  logic          busy,
  output logic [1:0]    lat_q,
  output logic [LW-1:0] bl_q,
  output logic          ws_q,
  output logic          err_q
);

  mode_word_t    w;
  logic [1:0]    lat_dec;
  logic [LW-1:0] bl_dec;
  logic          lat_ok, bl_ok, op_ok, legal;
  logic          unused_bits;

  assign w           = mode_word_t'(word);
  assign unused_bits = ^{w.spare, w.order};
  assign op_ok       = (w.op == 2'b00);
  assign legal       = lat_ok && bl_ok && op_ok;

  always_comb begin
    lat_ok  = 1'b1;
    lat_dec = 2'd1;
    case (w.lat)
      3'b001:  lat_dec = 2'd1;
      3'b010:  lat_dec = 2'd2;
      3'b011:  lat_dec = 2'd3;
      default: lat_ok  = 1'b0;
    endcase
  end

  generate
    if (FULL_PAGE_EN) begin : g_page
      always_comb begin
        bl_ok  = 1'b1;
        bl_dec = LW'(1);
        case (w.blen)
          BL_1:    bl_dec = LW'(1);
          BL_2:    bl_dec = LW'(2);
          BL_4:    bl_dec = LW'(4);
          BL_8:    bl_dec = LW'(8);
          BL_PAGE: bl_dec = LW'(PAGE_LEN);
          default: bl_ok  = 1'b0;
        endcase
      end
    end else begin : g_nopage
      always_comb begin
        bl_ok  = 1'b1;
        bl_dec = LW'(1);
        case (w.blen)
          BL_1:    bl_dec = LW'(1);
          BL_2:    bl_dec = LW'(2);
          BL_4:    bl_dec = LW'(4);
          BL_8:    bl_dec = LW'(8);
          default: bl_ok  = 1'b0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 2'(RST_LAT);
      bl_q  <= LW'(1);
      ws_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (load) begin
      if (busy || !legal) begin
        err_q <= 1'b1;
      end else begin
        lat_q <= lat_dec;
        bl_q  <= bl_dec;
        ws_q  <= w.wr_single;
        err_q <= 1'b0;
      end
    end
  end

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (lat_q != 2'd0)); // R2
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (load && busy) |=> (err_q && $stable(lat_q) && $stable(bl_q) && $stable(ws_q))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> ($stable(lat_q) && $stable(bl_q) && $stable(ws_q) && $stable(err_q))); // R11

endmodule

// File: rtl/sdram_rd_track.sv
module sdram_rd_track #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_cmd,
  input  logic [1:0]    lat,
  input  logic [LW-1:0] bl,
  output logic          rd_valid,
  output logic          rd_turn,
  output logic          busy
);

  logic [1:0]    dly;
  logic [LW-1:0] left;

  assign busy = (dly != 2'd0) || (left != '0) || rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly      <= 2'd0;
      left     <= '0;
      rd_valid <= 1'b0;
      rd_turn  <= 1'b0;
    end else if (rd_cmd) begin
      dly      <= lat - 2'd1;
      left     <= bl;
      rd_valid <= 1'b0;
      rd_turn  <= (lat == 2'd1);
    end else if (dly != 2'd0) begin
      dly      <= dly - 2'd1;
      rd_valid <= 1'b0;
      rd_turn  <= (dly == 2'd1);
    end else if (left != '0) begin
      left     <= left - LW'(1);
      rd_valid <= 1'b1;
      rd_turn  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_turn  <= 1'b0;
    end
  end

  AST_TURN_LEADS: assert property (@(posedge clk) disable iff (rst)
    (rd_turn && !rd_cmd) |=> rd_valid); // R4
  AST_TURN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_turn && !rd_cmd) |=> !rd_turn); // R4
  AST_BEATS_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (!rd_cmd) |=> (left <= $past(left))); // R5
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |=> !rd_valid); // R6

endmodule

// File: rtl/sdram_wr_track.sv
module sdram_wr_track #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          wr_single,
  input  logic [LW-1:0] bl,
  output logic          wr_req,
  output logic          busy
);

  logic [LW-1:0] cnt;
  logic [LW-1:0] wlen;

  assign wlen   = wr_single ? LW'(1) : bl;
  assign busy   = (cnt != '0);
  assign wr_req = wr_cmd || busy;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (wr_cmd)     cnt <= wlen - LW'(1);
    else if (cnt != '0)  cnt <= cnt - LW'(1);
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wr_single) |=> (!wr_req || wr_cmd)); // R9
  AST_WR_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (!wr_cmd) |=> (cnt <= $past(cnt))); // R8

endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer #(
  parameter int PAGE_LEN     = 256,
  parameter bit FULL_PAGE_EN = 1'b1,
  parameter int RST_LAT      = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_load,
  input  logic [11:0] mode_word,
  input  logic        rd_cmd,
  input  logic        wr_cmd,
  output logic        rd_valid,
  output logic        rd_turn,
  output logic        wr_req,
  output logic        mode_err
);

  localparam int LW = $clog2(PAGE_LEN + 1);

  logic [1:0]    lat_q;
  logic [LW-1:0] bl_q;
  logic          ws_q;
  logic          rd_busy, wr_busy, busy_any;

  assign busy_any = rd_busy || wr_busy || rd_cmd || wr_cmd;

  sdram_mode_reg #(
    .PAGE_LEN(PAGE_LEN), .FULL_PAGE_EN(FULL_PAGE_EN), .RST_LAT(RST_LAT), .LW(LW)
  ) u_mode (
    .clk(clk), .rst(rst), .load(mode_load), .word(mode_word), .busy(busy_any),
    .lat_q(lat_q), .bl_q(bl_q), .ws_q(ws_q), .err_q(mode_err)
  );

  sdram_rd_track #(.LW(LW)) u_rd (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .lat(lat_q), .bl(bl_q),
    .rd_valid(rd_valid), .rd_turn(rd_turn), .busy(rd_busy)
  );

  sdram_wr_track #(.LW(LW)) u_wr (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_single(ws_q), .bl(bl_q),
    .wr_req(wr_req), .busy(wr_busy)
  );

  AST_CMD_LOAD_REJECT: assert property (@(posedge clk) disable iff (rst)
    (mode_load && (rd_cmd || wr_cmd)) |=> mode_err); // R10

endmodule

// File: tb/sim_sdram_burst_timer.sv
module sim_sdram_burst_timer;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE       = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic        rd_cmd = 1'b0;
  logic        wr_cmd = 1'b0;
  logic        rd_valid, rd_turn, wr_req, mode_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_timer #(.PAGE_LEN(PAGE), .FULL_PAGE_EN(1'b1), .RST_LAT(2)) u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .rd_valid(rd_valid), .rd_turn(rd_turn),
    .wr_req(wr_req), .mode_err(mode_err)
  );

  function automatic logic [11:0] mk(logic [2:0] bl, logic [2:0] lat,
                                     logic [1:0] op, logic ws);
    return {2'b00, ws, op, lat, 1'b0, bl};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_mode(logic [11:0] w);
    @(negedge clk); mode_word = w; mode_load = 1'b1;
    @(posedge clk);
    @(negedge clk); mode_load = 1'b0;
  endtask

  // READ at edge n; state after edge n+k is sampled at index k.
  task automatic do_read(int m, int bl, string req);
    @(negedge clk); rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_cmd = 1'b0;
    for (int k = 0; k < m + bl + 2; k++) begin
      chk(rd_valid == ((k >= m) && (k < m + bl)), req, rd_valid, (k >= m) && (k < m + bl));
      chk(rd_turn == (k == m - 1), req, rd_turn, k == m - 1);
      @(negedge clk);
    end
  endtask

  task automatic do_write(int len, string req);
    @(negedge clk); wr_cmd = 1'b1; #1;
    chk(wr_req == 1'b1, req, wr_req, 1);
    @(posedge clk);
    @(negedge clk); wr_cmd = 1'b0; #1;
    for (int k = 1; k <= len; k++) begin
      chk(wr_req == (k < len), req, wr_req, k < len);
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset;
    chk(!rd_valid && !rd_turn && !wr_req, "R1", {rd_valid, rd_turn, wr_req}, 0);
    chk(mode_err == 1'b0, "R1", mode_err, 0);
    do_read(2, 1, "R1");
  endtask

  task automatic t_latencies;
    load_mode(mk(3'b001, 3'b001, 2'b00, 1'b0));
    chk(mode_err == 1'b0, "R11", mode_err, 0);
    do_read(1, 2, "R3");
    load_mode(mk(3'b011, 3'b011, 2'b00, 1'b0));
    do_read(3, 8, "R5");
    load_mode(mk(3'b010, 3'b010, 2'b00, 1'b0));
    do_read(2, 4, "R4");
    load_mode(mk(3'b111, 3'b010, 2'b00, 1'b0));
    do_read(2, PAGE, "R5");
  endtask

  task automatic t_read_restart;
    load_mode(mk(3'b011, 3'b011, 2'b00, 1'b0));
    @(negedge clk); rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_cmd = 1'b0;
    repeat (3) @(negedge clk);
    do_read(3, 8, "R6");
  endtask

  task automatic t_writes;
    load_mode(mk(3'b010, 3'b010, 2'b00, 1'b0));
    do_write(4, "R8");
    @(negedge clk); wr_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_cmd = 1'b0;
    do_write(4, "R12");
    load_mode(mk(3'b010, 3'b010, 2'b00, 1'b1));
    do_write(1, "R9");
    do_read(2, 4, "R9");
  endtask

  task automatic t_illegal;
    load_mode(mk(3'b001, 3'b010, 2'b00, 1'b0));
    load_mode(mk(3'b001, 3'b000, 2'b00, 1'b0));
    chk(mode_err == 1'b1, "R2", mode_err, 1);
    do_read(2, 2, "R2");
    load_mode(mk(3'b000, 3'b100, 2'b00, 1'b0));
    chk(mode_err == 1'b1, "R2", mode_err, 1);
    load_mode(mk(3'b000, 3'b001, 2'b01, 1'b0));
    chk(mode_err == 1'b1, "R7", mode_err, 1);
    do_read(2, 2, "R7");
    load_mode(mk(3'b100, 3'b011, 2'b00, 1'b0));
    chk(mode_err == 1'b1, "R5", mode_err, 1);
    do_read(2, 2, "R5");
    load_mode(mk(3'b001, 3'b011, 2'b00, 1'b0));
    chk(mode_err == 1'b0, "R11", mode_err, 0);
    do_read(3, 2, "R11");
  endtask

  task automatic t_busy_load;
    load_mode(mk(3'b011, 3'b010, 2'b00, 1'b0));
    @(negedge clk); rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_cmd = 1'b0;
    @(negedge clk);
    load_mode(mk(3'b000, 3'b011, 2'b00, 1'b0));
    chk(mode_err == 1'b1, "R10", mode_err, 1);
    repeat (12) @(negedge clk);
    do_read(2, 8, "R10");
    @(negedge clk); mode_word = mk(3'b000, 3'b001, 2'b00, 1'b0);
    mode_load = 1'b1; wr_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk); mode_load = 1'b0; wr_cmd = 1'b0;
    chk(mode_err == 1'b1, "R10", mode_err, 1);
    repeat (10) @(negedge clk);
    do_read(2, 8, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latencies();
    t_read_restart();
    t_writes();
    t_illegal();
    t_busy_load();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule